// File: doc/BRIEF.md
# Register Port Selection Decode

This block is the control logic that sits between instruction fetch and the register file of a processor that runs one instruction at a time. It reads the opcode and the two register identifiers from the fetched instruction. From them it chooses two read ports (`src_a`, `src_b`) and two write targets: `dst_e` takes the ALU result and `dst_m` takes the value loaded from memory. It also picks the sources for the two ALU inputs. It holds no state, so every output follows the current inputs within the same cycle.

The register identifier `NONE_ID` (default 8) on a read or write port means that port is idle. The stack instructions name the stack pointer (`SP_ID`, default 4) on several ports at once, even though the instruction encoding never states it. A pop updates two registers in one instruction. When both write targets name the same register, a generate-selected arbiter keeps only one of them. By default the memory result wins.

Top module: `regport_decode`

## Requirements
- R1: For the arithmetic/logic opcode (0x6), `src_a` = rA, `src_b` = rB, `dst_e` = rB, `dst_m` = none (8), ALU A select = valA (code 0) and ALU B select = valB (code 0).
- R2: For the register-to-memory store (0x4), `src_a` = rA, `src_b` = rB, both write targets are none (8), ALU A = valC (code 1) and ALU B = valB (code 0).
- R3: For pop (0xB) with rA different from the stack pointer, `src_a` = `src_b` = `dst_e` = stack pointer (4), `dst_m` = rA, ALU A = +step (code 2) and ALU B = valB (code 0).
- R4: For push (0xA), `src_a` = rA, `src_b` = `dst_e` = stack pointer, `dst_m` = none, ALU A = −step (code 3) and ALU B = valB.
- R5: For the memory-to-register load (0x5), `src_a` = none, `src_b` = rB, `dst_e` = none, `dst_m` = rA, ALU A = valC and ALU B = valB.
- R6: For the immediate move (0x3), reads are none, `dst_e` = rB, and the ALU selects valC plus zero (A code 1, B code 1). For the register move (0x2), `src_a` = rA, `src_b` = none, `dst_e` = rB, and the ALU selects valA plus zero (A code 0, B code 1).
- R7: Call (0x8) drives `src_a` = none, `src_b` = `dst_e` = stack pointer and ALU A = −step. Return (0x9) drives `src_a` = `src_b` = `dst_e` = stack pointer and ALU A = +step. For both, `dst_m` = none and ALU B = valB.
- R8: For nop (0x0), halt (0x1), jump (0x7) and the undefined codes 0xC to 0xF, all four register ports are none (8), ALU A select = unused (code 4) and ALU B select = unused (code 2).
- R9: When the two write targets would name the same register, as in a pop into the stack pointer, `dst_m` keeps it and `dst_e` becomes none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| icode_i | input | 4 | Opcode of the fetched instruction |
| reg_a_i | input | REG_W | rA field from the register byte |
| reg_b_i | input | REG_W | rB field from the register byte |
| src_a_o | output | REG_W | Read address of port A |
| src_b_o | output | REG_W | Read address of port B |
| dst_e_o | output | REG_W | Write target of the ALU result |
| dst_m_o | output | REG_W | Write target of the memory result |
| alu_a_sel_o | output | 3 | ALU A source: 0 valA, 1 valC, 2 +step, 3 −step, 4 unused |
| alu_b_sel_o | output | 2 | ALU B source: 0 valB, 1 zero, 2 unused |

## Verification
The block has no registers, so any wrong selection shows on the ports in the same cycle as the opcode that causes it. One opcode steering a read port wrongly and another steering a write target wrongly look alike from the outside. For that reason every directed vector compares all six outputs together. The stack opcodes, and a pop whose destination is the stack pointer itself, get their own vectors, because only those expose a missing implicit stack port or a lost arbitration.

// File: rtl/regport_pkg.sv
package regport_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_NOP   = 4'h0;
   localparam logic [OPC_W-1:0] OP_HALT  = 4'h1;
   localparam logic [OPC_W-1:0] OP_RRMOV = 4'h2;
   localparam logic [OPC_W-1:0] OP_IRMOV = 4'h3;
   localparam logic [OPC_W-1:0] OP_RMMOV = 4'h4;
   localparam logic [OPC_W-1:0] OP_MRMOV = 4'h5;
   localparam logic [OPC_W-1:0] OP_ARITH = 4'h6;
   localparam logic [OPC_W-1:0] OP_JUMP  = 4'h7;
   localparam logic [OPC_W-1:0] OP_CALL  = 4'h8;
   localparam logic [OPC_W-1:0] OP_RET   = 4'h9;
   localparam logic [OPC_W-1:0] OP_PUSH  = 4'hA;
   localparam logic [OPC_W-1:0] OP_POP   = 4'hB;

   localparam int ALUA_W = 3;
   localparam int ALUB_W = 2;

   typedef enum logic [ALUA_W-1:0] {
      ALUA_VALA  = 3'd0,
      ALUA_VALC  = 3'd1,
      ALUA_PLUS  = 3'd2,
      ALUA_MINUS = 3'd3,
      ALUA_OFF   = 3'd4
   } alu_a_e;

   typedef enum logic [ALUB_W-1:0] {
      ALUB_VALB = 2'd0,
      ALUB_ZERO = 2'd1,
      ALUB_OFF  = 2'd2
   } alu_b_e;
endpackage

// File: rtl/regport_src.sv
module regport_src
   import regport_pkg::*;
#(
   parameter int REG_W   = 4,
   parameter int SP_ID   = 4,
   parameter int NONE_ID = 8
) (
   input  logic [OPC_W-1:0] icode_i,
   input  logic [REG_W-1:0] reg_a_i,
   input  logic [REG_W-1:0] reg_b_i,
   output logic [REG_W-1:0] src_a_o,
   output logic [REG_W-1:0] src_b_o
);
   localparam logic [REG_W-1:0] NONE_R = REG_W'(NONE_ID);
   localparam logic [REG_W-1:0] SP_R   = REG_W'(SP_ID);

   always_comb begin
      src_a_o = NONE_R;
      src_b_o = NONE_R;
      case (icode_i)
         OP_RRMOV: src_a_o = reg_a_i;
         OP_RMMOV, OP_ARITH: begin
            src_a_o = reg_a_i;
            src_b_o = reg_b_i;
         end
         OP_MRMOV: src_b_o = reg_b_i;
         OP_PUSH: begin
            src_a_o = reg_a_i;
            src_b_o = SP_R;
         end
         OP_POP, OP_RET: begin
            src_a_o = SP_R;
            src_b_o = SP_R;
         end
         OP_CALL: src_b_o = SP_R;
         default: ;
      endcase
   end
endmodule

// File: rtl/regport_dst.sv
module regport_dst
   import regport_pkg::*;
#(
   parameter int REG_W   = 4,
   parameter int SP_ID   = 4,
   parameter int NONE_ID = 8
) (
   input  logic [OPC_W-1:0] icode_i,
   input  logic [REG_W-1:0] reg_a_i,
   input  logic [REG_W-1:0] reg_b_i,
   output logic [REG_W-1:0] dst_e_o,
   output logic [REG_W-1:0] dst_m_o
);
   localparam logic [REG_W-1:0] NONE_R = REG_W'(NONE_ID);
   localparam logic [REG_W-1:0] SP_R   = REG_W'(SP_ID);

   always_comb begin
      dst_e_o = NONE_R;
      dst_m_o = NONE_R;
      case (icode_i)
         OP_RRMOV, OP_IRMOV, OP_ARITH: dst_e_o = reg_b_i;
         OP_MRMOV: dst_m_o = reg_a_i;
         OP_PUSH, OP_CALL, OP_RET: dst_e_o = SP_R;
         OP_POP: begin
            dst_e_o = SP_R;
            dst_m_o = reg_a_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/regport_alu.sv
module regport_alu
   import regport_pkg::*;
(
   input  logic [OPC_W-1:0] icode_i,
   output alu_a_e           alu_a_o,
   output alu_b_e           alu_b_o
);
   always_comb begin
      alu_a_o = ALUA_OFF;
      alu_b_o = ALUB_OFF;
      case (icode_i)
         OP_RRMOV: begin alu_a_o = ALUA_VALA;  alu_b_o = ALUB_ZERO; end
         OP_IRMOV: begin alu_a_o = ALUA_VALC;  alu_b_o = ALUB_ZERO; end
         OP_RMMOV, OP_MRMOV: begin alu_a_o = ALUA_VALC; alu_b_o = ALUB_VALB; end
         OP_ARITH: begin alu_a_o = ALUA_VALA;  alu_b_o = ALUB_VALB; end
         OP_PUSH, OP_CALL: begin alu_a_o = ALUA_MINUS; alu_b_o = ALUB_VALB; end
         OP_POP, OP_RET: begin alu_a_o = ALUA_PLUS; alu_b_o = ALUB_VALB; end
         default: ;
      endcase
   end
endmodule

// File: rtl/regport_arb.sv
module regport_arb #(
   parameter int REG_W    = 4,
   parameter int NONE_ID  = 8,
   parameter bit MEM_WINS = 1'b1
) (
   input  logic [REG_W-1:0] dst_e_i,
   input  logic [REG_W-1:0] dst_m_i,
   output logic [REG_W-1:0] dst_e_o,
   output logic [REG_W-1:0] dst_m_o
);
   localparam logic [REG_W-1:0] NONE_R = REG_W'(NONE_ID);

   logic clash;
   assign clash = (dst_e_i != NONE_R) && (dst_e_i == dst_m_i);

   generate
      if (MEM_WINS) begin : g_mem_first
         assign dst_e_o = clash ? NONE_R : dst_e_i;
         assign dst_m_o = dst_m_i;
      end else begin : g_alu_first
         assign dst_e_o = dst_e_i;
         assign dst_m_o = clash ? NONE_R : dst_m_i;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({dst_e_i, dst_m_i})) begin
         // R9: after arbitration at most one target is named
         a_r9_single_target: assert (dst_e_o == NONE_R || dst_e_o != dst_m_o);
      end
   end
endmodule

// File: rtl/regport_decode.sv
module regport_decode
   import regport_pkg::*;
#(
   parameter int REG_W    = 4,
   parameter int SP_ID    = 4,
   parameter int NONE_ID  = 8,
   parameter bit MEM_WINS = 1'b1
) (
   input  logic [3:0]       icode_i,
   input  logic [REG_W-1:0] reg_a_i,
   input  logic [REG_W-1:0] reg_b_i,
   output logic [REG_W-1:0] src_a_o,
   output logic [REG_W-1:0] src_b_o,
   output logic [REG_W-1:0] dst_e_o,
   output logic [REG_W-1:0] dst_m_o,
   output logic [2:0]       alu_a_sel_o,
   output logic [1:0]       alu_b_sel_o
);
   localparam logic [REG_W-1:0] NONE_R = REG_W'(NONE_ID);
   localparam logic [REG_W-1:0] SP_R   = REG_W'(SP_ID);

   generate
      if (NONE_ID >= (1 << REG_W) || SP_ID >= (1 << REG_W)) begin : g_bad_width
         $error("register identifiers do not fit REG_W");
      end
      if (SP_ID == NONE_ID) begin : g_bad_ids
         $error("stack pointer and idle identifier collide");
      end
   endgenerate

   logic [REG_W-1:0] dst_e_raw, dst_m_raw;
   alu_a_e alu_a;
   alu_b_e alu_b;

   regport_src #(.REG_W(REG_W), .SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_src (
      .icode_i(icode_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i),
      .src_a_o(src_a_o), .src_b_o(src_b_o)
   );

   regport_dst #(.REG_W(REG_W), .SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_dst (
      .icode_i(icode_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i),
      .dst_e_o(dst_e_raw), .dst_m_o(dst_m_raw)
   );

   regport_alu u_alu (
      .icode_i(icode_i), .alu_a_o(alu_a), .alu_b_o(alu_b)
   );

   regport_arb #(.REG_W(REG_W), .NONE_ID(NONE_ID), .MEM_WINS(MEM_WINS)) u_arb (
      .dst_e_i(dst_e_raw), .dst_m_i(dst_m_raw),
      .dst_e_o(dst_e_o), .dst_m_o(dst_m_o)
   );

   assign alu_a_sel_o = alu_a;
   assign alu_b_sel_o = alu_b;

   always_comb begin
      if (!$isunknown({icode_i, reg_a_i, reg_b_i})) begin
         // R3: a stack-step ALU input always pairs with a stack read and write
         a_r3_stack_adjust: assert (!(alu_a == ALUA_PLUS || alu_a == ALUA_MINUS)
                                    || (src_b_o == SP_R && dst_e_raw == SP_R));
         // R1: whenever valB feeds the ALU, port B reads rB or the stack pointer
         a_r1_valb_source: assert (alu_b != ALUB_VALB
                                   || src_b_o == reg_b_i || src_b_o == SP_R);
         // R2: a store writes no register
         a_r2_store_quiet: assert (icode_i != OP_RMMOV
                                   || (dst_e_o == NONE_R && dst_m_o == NONE_R));
         // R8: an unused ALU implies every register port idle
         a_r8_idle_ports: assert (alu_a != ALUA_OFF
                                  || (src_a_o == NONE_R && src_b_o == NONE_R &&
                                      dst_e_o == NONE_R && dst_m_o == NONE_R));
      end
   end
endmodule

// File: tb/regport_decode_tb.sv
`timescale 1ns/1ps
module regport_decode_tb_top;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [3:0] icode, ra, rb;
   logic [3:0] src_a, src_b, dst_e, dst_m;
   logic [2:0] alu_a;
   logic [1:0] alu_b;

   int vectors = 0;
   int errors  = 0;

   regport_decode dut_i (
      .icode_i(icode), .reg_a_i(ra), .reg_b_i(rb),
      .src_a_o(src_a), .src_b_o(src_b), .dst_e_o(dst_e), .dst_m_o(dst_m),
      .alu_a_sel_o(alu_a), .alu_b_sel_o(alu_b)
   );

   task automatic apply(input string req, input logic [3:0] op, a, b,
                        input logic [3:0] e_sa, e_sb, e_de, e_dm,
                        input logic [2:0] e_aa, input logic [1:0] e_ab);
      @(posedge clk);
      icode = op; ra = a; rb = b;
      @(negedge clk);
      vectors++;
      if ({src_a, src_b, dst_e, dst_m, alu_a, alu_b} !== {e_sa, e_sb, e_de, e_dm, e_aa, e_ab}) begin
         errors++;
         $display("FAIL %s op=%h: got sa=%0d sb=%0d de=%0d dm=%0d aa=%0d ab=%0d exp sa=%0d sb=%0d de=%0d dm=%0d aa=%0d ab=%0d",
                  req, op, src_a, src_b, dst_e, dst_m, alu_a, alu_b,
                  e_sa, e_sb, e_de, e_dm, e_aa, e_ab);
      end
   endtask

   task automatic t_idle;          // R8
      apply("R8", 4'h0, 4'd1, 4'd2, 8, 8, 8, 8, 4, 2);
      apply("R8", 4'h1, 4'd3, 4'd5, 8, 8, 8, 8, 4, 2);
      apply("R8", 4'h7, 4'd4, 4'd4, 8, 8, 8, 8, 4, 2);
      for (int op = 12; op < 16; op++)
         apply("R8", 4'(op), 4'd6, 4'd7, 8, 8, 8, 8, 4, 2);
   endtask

   task automatic t_arith;         // R1
      apply("R1", 4'h6, 4'd1, 4'd3, 1, 3, 3, 8, 0, 0);
      apply("R1", 4'h6, 4'd6, 4'd0, 6, 0, 0, 8, 0, 0);
   endtask

   task automatic t_store;         // R2
      apply("R2", 4'h4, 4'd2, 4'd5, 2, 5, 8, 8, 1, 0);
   endtask

   task automatic t_pop;           // R3
      apply("R3", 4'hB, 4'd0, 4'd8, 4, 4, 4, 0, 2, 0);
      apply("R3", 4'hB, 4'd7, 4'd8, 4, 4, 4, 7, 2, 0);
   endtask

   task automatic t_push;          // R4
      apply("R4", 4'hA, 4'd6, 4'd8, 6, 4, 4, 8, 3, 0);
   endtask

   task automatic t_load;          // R5
      apply("R5", 4'h5, 4'd3, 4'd7, 8, 7, 8, 3, 1, 0);
   endtask

   task automatic t_moves;         // R6
      apply("R6", 4'h3, 4'd8, 4'd2, 8, 8, 2, 8, 1, 1);
      apply("R6", 4'h2, 4'd1, 4'd6, 1, 8, 6, 8, 0, 1);
   endtask

   task automatic t_call_ret;      // R7
      apply("R7", 4'h8, 4'd8, 4'd8, 8, 4, 4, 8, 3, 0);
      apply("R7", 4'h9, 4'd8, 4'd8, 4, 4, 4, 8, 2, 0);
   endtask

   task automatic t_clash;         // R9
      apply("R9", 4'hB, 4'd4, 4'd8, 4, 4, 8, 4, 2, 0);
   endtask

   initial begin
      icode = 4'h0; ra = 4'd8; rb = 4'd8;
      t_idle();
      t_arith();
      t_store();
      t_pop();
      t_push();
      t_load();
      t_moves();
      t_call_ret();
      t_clash();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule